// File: doc/BRIEF.md
# Timing-Recovery Phase Loop with Selectable Order

This block closes a digital phase-locked loop for symbol timing recovery in a multicarrier receiver. Once per symbol, the demapping stage supplies a signed measurement of how far the receive clock has drifted from the transmit clock. The block forms a proportional term and an integral term from that sample. In third-order operation it adds a second, cascaded integrator. It sums these terms into a filter output, and a wide phase accumulator integrates that output. The top bits of the accumulator form the phase word. Downstream logic uses this word to rotate every carrier in both the transmit and the receive direction.

Each path gets its gain from an arithmetic right shift, so loop bandwidths that span several decades only need shift settings. All integrators in the loop filter clamp at their limits. The phase accumulator wraps, because the phase it holds is circular. A synchronous clear returns the whole loop to zero, for example on retrain.

Top module: `tr_dpll_top`

## Requirements
- R1: While `rst` is high and after it falls, `ph_out` is 0 and `ph_vld` is 0 until the first strobe has passed through the loop.
- R2: If `err_vld` is high in clock cycle n, `ph_vld` is high in cycle n+2. `ph_vld` is high only in cycles that follow such a strobe by exactly two cycles, so back-to-back strobes give back-to-back pulses.
- R3: When `err_vld` is low, no loop state changes. `ph_out` keeps its value whatever `err_in` and the shift inputs do.
- R4: The proportional term P is the sign-extended `err_in`, arithmetically shifted right by `kp_shift`.
- R5: On each strobe, integrator I adds the sign-extended `err_in` arithmetically shifted right by `ki_shift`. The sum clamps to the range [-2^(ACC_W-1), 2^(ACC_W-1)-1] and never wraps.
- R6: With `cfg_third` = 1 (third order), integrator J adds the value of I from before this strobe, shifted right by `k2_shift`, and clamps like I. The filter output is F = clamp(P + I + J), using the updated I and J.
- R7: With `cfg_third` = 0 (second order), J is forced to zero on every clock, and F = clamp(P + I).
- R8: On each strobe, the ACC_W-bit phase accumulator becomes (accumulator + F) modulo 2^ACC_W. `ph_out` is its top PH_W bits.
- R9: A synchronous `clr` zeroes I, J, the phase accumulator, `ph_out` and any pulse in flight. It takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous loop clear |
| err_vld | input | 1 | Strobe marking a phase-error sample |
| err_in | input | ERR_W | Signed phase-error sample |
| cfg_third | input | 1 | Loop order: 1 = third, 0 = second |
| kp_shift | input | SH_W | Right shift for the proportional path |
| ki_shift | input | SH_W | Right shift for the first integrator |
| k2_shift | input | SH_W | Right shift for the second integrator |
| ph_out | output | PH_W | Phase word for carrier rotation |
| ph_vld | output | 1 | Pulse marking an updated phase word |

## Verification
The hardest conditions to reach are the clamped integrators and the clamped filter sum. At full-scale input with a zero shift, the first integrator needs a few hundred strobes to reach its positive limit, and twice that to cross to the negative one. The bench therefore runs long full-scale runs in both polarities, checking every phase word against a wide-integer model. It then lets the cascaded integrator in third order saturate the filter sum, so the phase accumulator also wraps many times. A clear that coincides with a strobe, and a switch from third to second order with a nonzero second integrator, are set up directly.

// File: rtl/tr_dpll_pkg.sv
package tr_dpll_pkg;
  typedef enum logic {
    ORD_SECOND = 1'b0,
    ORD_THIRD  = 1'b1
  } loop_order_e;
endpackage

// File: rtl/tr_dpll_sat_acc.sv
module tr_dpll_sat_acc #(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                en,
  input  logic                hold_zero,
  input  logic signed [W-1:0] addend,
  output logic signed [W-1:0] acc
);
  logic signed [W:0]   sum;
  logic signed [W-1:0] acc_nxt;

  assign sum = {acc[W-1], acc} + {addend[W-1], addend};
  // top two bits disagree -> out of range, clamp toward the sign of the sum
  assign acc_nxt = (sum[W] ^ sum[W-1]) ? {sum[W], {(W-1){~sum[W]}}} : sum[W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr || hold_zero) acc <= '0;
    else if (en)                 acc <= acc_nxt;
  end

  // R7: a held integrator reads zero on the following cycle
  a_r7_hold_zero: assert property (@(posedge clk) disable iff (rst)
    hold_zero |=> (acc == '0));
  // R5: a non-negative step from a non-negative value never wraps negative
  a_r5_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && !hold_zero && !addend[W-1] && !acc[W-1])
      |=> ($signed(acc) >= $signed($past(acc))));
  // R5: a negative step from a negative value never wraps positive
  a_r5_no_wrap_dn: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && !hold_zero && addend[W-1] && acc[W-1])
      |=> ($signed(acc) <= $signed($past(acc))));
endmodule

// File: rtl/tr_dpll_pi_stage.sv
module tr_dpll_pi_stage
  import tr_dpll_pkg::*;
#(
  parameter int ERR_W = 16,
  parameter int ACC_W = 24,   // must exceed ERR_W
  parameter int SH_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    en,
  input  loop_order_e             order,
  input  logic signed [ERR_W-1:0] err,
  input  logic [SH_W-1:0]         kp,
  input  logic [SH_W-1:0]         ki,
  input  logic [SH_W-1:0]         k2,
  output logic signed [ACC_W-1:0] prop_q,
  output logic signed [ACC_W-1:0] int1_q,
  output logic signed [ACC_W-1:0] int2_q,
  output logic                    vld_q
);
  localparam int EXT_W = ACC_W - ERR_W;

  logic signed [ACC_W-1:0] err_ext;
  logic signed [ACC_W-1:0] int1_add;
  logic signed [ACC_W-1:0] int2_add;

  assign err_ext  = {{EXT_W{err[ERR_W-1]}}, err};
  assign int1_add = err_ext >>> ki;
  // second integrator uses the registered first integrator, keeping adders apart
  assign int2_add = int1_q >>> k2;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prop_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= en;
      if (en) prop_q <= err_ext >>> kp;
    end
  end

  tr_dpll_sat_acc #(.W(ACC_W)) int1_i (
    .clk(clk), .rst(rst), .clr(clr), .en(en), .hold_zero(1'b0),
    .addend(int1_add), .acc(int1_q)
  );

  tr_dpll_sat_acc #(.W(ACC_W)) int2_i (
    .clk(clk), .rst(rst), .clr(clr), .en(en), .hold_zero(order == ORD_SECOND),
    .addend(int2_add), .acc(int2_q)
  );

  // R3: without a strobe the proportional register holds
  a_r3_prop_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(prop_q));
endmodule

// File: rtl/tr_dpll_phase_acc.sv
module tr_dpll_phase_acc #(
  parameter int ACC_W = 24,
  parameter int PH_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] prop,
  input  logic signed [ACC_W-1:0] int1,
  input  logic signed [ACC_W-1:0] int2,
  output logic [PH_W-1:0]         ph_out,
  output logic                    ph_vld
);
  localparam int SUM_W = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] FMAX = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] FMIN = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [SUM_W-1:0] s3;
  logic signed [ACC_W-1:0] filt;
  logic [ACC_W-1:0]        ph_acc;

  assign s3 = {{2{prop[ACC_W-1]}}, prop} + {{2{int1[ACC_W-1]}}, int1}
            + {{2{int2[ACC_W-1]}}, int2};

  always_comb begin
    if (s3 > FMAX)      filt = FMAX[ACC_W-1:0];
    else if (s3 < FMIN) filt = FMIN[ACC_W-1:0];
    else                filt = s3[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph_acc <= '0;
      ph_vld <= 1'b0;
    end else begin
      ph_vld <= en;
      if (en) ph_acc <= ph_acc + filt;   // modulo 2^ACC_W: one full turn
    end
  end

  assign ph_out = ph_acc[ACC_W-1 -: PH_W];

  // R3: phase holds between strobes
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(ph_acc));
  // R9: clear empties phase and pulse
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ph_acc == '0 && !ph_vld));
  // R2: a pulse only follows a filter update
  a_r2_pulse_src: assert property (@(posedge clk) disable iff (rst)
    ph_vld |-> $past(en));
endmodule

// File: rtl/tr_dpll_top.sv
module tr_dpll_top
  import tr_dpll_pkg::*;
#(
  parameter int ERR_W = 16,
  parameter int ACC_W = 24,
  parameter int PH_W  = 16,
  parameter int SH_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             err_vld,
  input  logic [ERR_W-1:0] err_in,
  input  logic             cfg_third,
  input  logic [SH_W-1:0]  kp_shift,
  input  logic [SH_W-1:0]  ki_shift,
  input  logic [SH_W-1:0]  k2_shift,
  output logic [PH_W-1:0]  ph_out,
  output logic             ph_vld
);
  logic signed [ACC_W-1:0] prop_q;
  logic signed [ACC_W-1:0] int1_q;
  logic signed [ACC_W-1:0] int2_q;
  logic                    stage_vld;
  loop_order_e             order;

  assign order = loop_order_e'(cfg_third);

  tr_dpll_pi_stage #(.ERR_W(ERR_W), .ACC_W(ACC_W), .SH_W(SH_W)) pi_i (
    .clk(clk), .rst(rst), .clr(clr), .en(err_vld), .order(order),
    .err(err_in), .kp(kp_shift), .ki(ki_shift), .k2(k2_shift),
    .prop_q(prop_q), .int1_q(int1_q), .int2_q(int2_q), .vld_q(stage_vld)
  );

  tr_dpll_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) ph_i (
    .clk(clk), .rst(rst), .clr(clr), .en(stage_vld),
    .prop(prop_q), .int1(int1_q), .int2(int2_q),
    .ph_out(ph_out), .ph_vld(ph_vld)
  );

  // R2: every strobe yields a pulse two cycles later
  a_r2_latency: assert property (@(posedge clk) disable iff (rst || clr)
    err_vld |=> ##1 ph_vld);
endmodule

// File: tb/tr_dpll_top_tb_top.sv
module tr_dpll_top_tb_top;
  localparam int ERR_W = 16;
  localparam int ACC_W = 24;
  localparam int PH_W  = 16;
  localparam int SH_W  = 5;
  localparam longint AMAX  = (longint'(1) <<< (ACC_W-1)) - 1;
  localparam longint AMIN  = -(longint'(1) <<< (ACC_W-1));
  localparam longint AMASK = (longint'(1) <<< ACC_W) - 1;
  localparam int NVEC = 8;
  // {third, k2, ki, kp, err}
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b0, 5'd0, 5'd4,  5'd2,  16'h0400},
    {1'b0, 5'd0, 5'd4,  5'd2,  16'hFC00},
    {1'b0, 5'd0, 5'd0,  5'd0,  16'h7FFF},
    {1'b1, 5'd3, 5'd2,  5'd1,  16'h1234},
    {1'b1, 5'd3, 5'd2,  5'd1,  16'h8000},
    {1'b1, 5'd0, 5'd5,  5'd31, 16'h0FFF},
    {1'b0, 5'd7, 5'd31, 5'd3,  16'hF00F},
    {1'b1, 5'd1, 5'd1,  5'd1,  16'h4000}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst, clr, err_vld, cfg_third, ph_vld;
  logic [ERR_W-1:0] err_in;
  logic [SH_W-1:0]  kp_shift, ki_shift, k2_shift;
  logic [PH_W-1:0]  ph_out;

  int checks = 0;
  int failures = 0;
  longint m_i1 = 0, m_i2 = 0, m_ph = 0, m_f = 0;

  tr_dpll_top #(.ERR_W(ERR_W), .ACC_W(ACC_W), .PH_W(PH_W), .SH_W(SH_W)) dut_i (
    .clk(clk), .rst(rst), .clr(clr), .err_vld(err_vld), .err_in(err_in),
    .cfg_third(cfg_third), .kp_shift(kp_shift), .ki_shift(ki_shift),
    .k2_shift(k2_shift), .ph_out(ph_out), .ph_vld(ph_vld)
  );

  function automatic longint clampv(longint v);
    if (v > AMAX) return AMAX;
    if (v < AMIN) return AMIN;
    return v;
  endfunction

  function automatic logic [PH_W-1:0] exp_ph();
    return PH_W'(m_ph >> (ACC_W - PH_W));
  endfunction

  task automatic model_clear();
    m_i1 = 0; m_i2 = 0; m_ph = 0;
  endtask

  task automatic model_step(input logic [ERR_W-1:0] e);
    longint ex, p;
    ex = longint'($signed(e));
    p  = ex >>> kp_shift;
    if (cfg_third) m_i2 = clampv(m_i2 + (m_i1 >>> k2_shift));
    else           m_i2 = 0;
    m_i1 = clampv(m_i1 + (ex >>> ki_shift));
    m_f  = clampv(p + m_i1 + m_i2);
    m_ph = (m_ph + m_f) & AMASK;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobe in cycle n, pulse and word checked in cycle n+2
  task automatic strobe(input logic [ERR_W-1:0] e, input string req);
    @(negedge clk);
    err_vld = 1'b1; err_in = e; model_step(e);
    @(negedge clk);
    err_vld = 1'b0; err_in = ~e;
    chk("R2 early", longint'(ph_vld), 0);
    @(negedge clk);
    chk("R2 pulse", longint'(ph_vld), 1);
    chk(req, longint'(ph_out), longint'(exp_ph()));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [PH_W-1:0] exp_q [4];
    logic [PH_W-1:0] held;
    rst = 1'b1; clr = 1'b0; err_vld = 1'b0; err_in = '0; cfg_third = 1'b0;
    kp_shift = '0; ki_shift = '0; k2_shift = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset word", longint'(ph_out), 0);
    chk("R1 reset pulse", longint'(ph_vld), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset word", longint'(ph_out), 0);
    chk("R1 after reset pulse", longint'(ph_vld), 0);

    // table walk: R4 R5 R6 R7 R8 under mixed gains and orders
    for (int v = 0; v < NVEC; v++) begin
      cfg_third = VEC[v][31];
      k2_shift  = VEC[v][30:26];
      ki_shift  = VEC[v][25:21];
      kp_shift  = VEC[v][20:16];
      strobe(VEC[v][15:0], "R4/R6/R7/R8 table");
    end

    // R3: idle with wiggling inputs
    held = ph_out;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      err_in = 16'(k * 9001); kp_shift = SH_W'(k); ki_shift = SH_W'(k + 1);
      chk("R3 idle hold", longint'(ph_out), longint'(held));
      chk("R3 idle pulse", longint'(ph_vld), 0);
    end

    // R2: back-to-back strobes, third order
    cfg_third = 1'b1; kp_shift = 5'd2; ki_shift = 5'd3; k2_shift = 5'd2;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R2 burst pulse", longint'(ph_vld), 1);
        chk("R8 burst word", longint'(ph_out), longint'(exp_q[i-2]));
      end
      if (i < 4) begin
        err_vld = 1'b1; err_in = 16'(i * 3000 - 4000);
        model_step(err_in);
        exp_q[i] = exp_ph();
      end else begin
        err_vld = 1'b0;
      end
    end
    @(negedge clk);
    chk("R2 burst end", longint'(ph_vld), 0);

    // R7: switch to second order with J nonzero
    cfg_third = 1'b0;
    strobe(16'h0321, "R7 order switch");

    // R9: clear in the same cycle as a strobe
    @(negedge clk);
    clr = 1'b1; err_vld = 1'b1; err_in = 16'h2000;
    @(negedge clk);
    clr = 1'b0; err_vld = 1'b0;
    model_clear();
    chk("R9 clear word", longint'(ph_out), 0);
    chk("R9 clear pulse", longint'(ph_vld), 0);
    @(negedge clk);
    chk("R9 strobe dropped", longint'(ph_vld), 0);
    kp_shift = 5'd1; ki_shift = 5'd2;
    strobe(16'h0100, "R9 restart from zero");

    // R5: drive I to its positive limit, then across to the negative limit
    cfg_third = 1'b0; kp_shift = 5'd0; ki_shift = 5'd0;
    for (int n = 0; n < 300; n++) strobe(16'h7FFF, "R5 positive clamp");
    for (int n = 0; n < 600; n++) strobe(16'h8000, "R5 negative clamp");

    // R6: cascaded integrator saturating the filter sum, phase wrapping (R8)
    cfg_third = 1'b1; k2_shift = 5'd0;
    for (int n = 0; n < 700; n++) strobe(16'h7FFF, "R6 third-order clamp");

    finish_run();
  end
endmodule